// File: doc/BRIEF.md
# Inverted Serial Transmitter with Resynchronisation Burst

This block is a transmit-only asynchronous serial port. It sends one bit per pulse on an external bit-period tick, a single-cycle strobe the surrounding logic raises once every 208 counts of a 1 MHz base, which gives 4800 baud. A caller hands over one byte at a time while the block reports that it is free. The block then sends a ten-bit character: a logical 0 start bit, the eight data bits with the least significant bit first, and a logical 1 stop bit.

A second request loads a burst of eight logical 1 bits with no start bit. A receiver that has lost its place in a continuous stream sees a long stretch of stop level and can realign on the next start bit. The pin carries the inverse of the logical bit, so a logical 1 (idle, stop) drives it low. This lets it feed an RS-232 level path without a line driver.

Both kinds of load are taken only while the block is free. A request that arrives while it is busy is dropped, not queued. The bits wait in a 16-bit buffer and leave from its low end, and a remaining-bit count falls by one for each bit sent.

Top module: `inv_uart_tx`

## Requirements
- R1: During and right after reset, `tx_pin` is 0 (logical idle level 1) and `busy` is 0.
- R2: A `load_valid` pulse while `busy` is 0 sets `busy` in the next cycle. The pin then stays at idle level until the next tick.
- R3: A character goes out as ten bit periods, each started by one `bit_tick` pulse: logical 0, then `load_data[0]` through `load_data[7]`, then logical 1.
- R4: `tx_pin` always drives the inverse of the logical bit: logical 1 gives pin 0, logical 0 gives pin 1.
- R5: `busy` stays 1 through the whole last bit period and falls only in the cycle after the tick that follows the final bit.
- R6: A `sync_req` pulse while `busy` is 0 sends eight periods of logical 1 (pin 0) with no start bit. `busy` is 1 during those eight periods and 0 after the ninth tick.
- R7: If `load_valid` and `sync_req` are high in the same idle cycle, the character is sent and the burst request is dropped.
- R8: `load_valid` and `sync_req` have no effect while `busy` is 1. The frame in progress keeps going unchanged, and nothing follows it.
- R9: `tx_pin` changes only in the cycle after a `bit_tick` pulse, and it stays at idle level whenever `busy` is 0, including when ticks arrive while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| load_valid | input | 1 | Request to send `load_data` as one character |
| load_data | input | 8 | Byte to send |
| sync_req | input | 1 | Request to send the stop-level burst |
| busy | output | 1 | High from a taken load until the last bit period ends |
| tx_pin | output | 1 | Inverted serial line |

## Verification
On every cycle, the assertions check four things. The pin moves only after a tick and sits at idle level whenever the block is free. `busy` rises after an accepted load and falls only in the cycle after a tick. Only the bench's scenarios can show the rest. That covers the order and value of each bit in a character and the length of the burst. It also covers which request wins when both arrive together, and that requests made during a frame leave no trace on the line.

// File: rtl/inv_tx_pkg.sv
package inv_tx_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CHAR = 2'd1,
    LD_SYNC = 2'd2
  } load_kind_e;
endpackage

// File: rtl/inv_tx_loader.sv
module inv_tx_loader
  import inv_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUF_W    = 16,
  parameter int SYNC_LEN = 8,
  parameter int CNT_W    = 5
) (
  input  logic              busy,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sync_req,
  output load_kind_e        kind,
  output logic [BUF_W-1:0]  img,
  output logic [CNT_W-1:0]  cnt
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic [BUF_W-1:0] char_img;

  // Start bit at the low end, data LSB first, stop bit, then idle-level fill.
  assign char_img[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_data
      assign char_img[gi+1] = load_data[gi];
    end
    for (gi = DATA_W + 1; gi < BUF_W; gi++) begin : g_fill
      assign char_img[gi] = 1'b1;
    end
  endgenerate

  always_comb begin
    kind = LD_NONE;
    img  = '1;
    cnt  = '0;
    if (!busy) begin
      if (load_valid) begin
        kind = LD_CHAR;
        img  = char_img;
        cnt  = CNT_W'(FRAME_LEN);
      end else if (sync_req) begin
        kind = LD_SYNC;
        img  = '1;
        cnt  = CNT_W'(SYNC_LEN);
      end
    end
  end
endmodule

// File: rtl/inv_tx_shifter.sv
module inv_tx_shifter
  import inv_tx_pkg::*;
#(
  parameter int BUF_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  load_kind_e       kind,
  input  logic [BUF_W-1:0] img,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             fire,
  output logic             head,
  output logic [CNT_W-1:0] remain
);
  logic [BUF_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire   = bit_tick && (cnt_q != '0);
  assign head   = buf_q[0];
  assign remain = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '1;
      cnt_q <= '0;
    end else if (kind != LD_NONE) begin
      buf_q <= img;
      cnt_q <= cnt_in;
    end else if (fire) begin
      buf_q <= {1'b1, buf_q[BUF_W-1:1]};
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/inv_tx_line.sv
module inv_tx_line
  import inv_tx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  load_kind_e       kind,
  input  logic             fire,
  input  logic             head,
  input  logic [CNT_W-1:0] remain,
  output logic             busy,
  output logic             pin
);
  logic active_q, active_n;
  logic pin_n;
  logic bits_left_n;

  always_comb begin
    active_n = active_q;
    pin_n    = pin;
    if (bit_tick) begin
      if (fire) begin
        active_n = 1'b1;
        pin_n    = ~head;
      end else begin
        active_n = 1'b0;
        pin_n    = 1'b0;
      end
    end
    if (kind != LD_NONE)
      bits_left_n = 1'b1;
    else if (fire)
      bits_left_n = (remain > CNT_W'(1));
    else
      bits_left_n = (remain != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pin      <= 1'b0;
      busy     <= 1'b0;
    end else begin
      active_q <= active_n;
      pin      <= pin_n;
      busy     <= bits_left_n || active_n;
    end
  end
endmodule

// File: rtl/inv_uart_tx.sv
module inv_uart_tx
  import inv_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUF_W    = 16,
  parameter int SYNC_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sync_req,
  output logic              busy,
  output logic              tx_pin
);
  localparam int CNT_W = $clog2(BUF_W + 1);

  load_kind_e       kind;
  logic [BUF_W-1:0] img;
  logic [CNT_W-1:0] cnt_ld;
  logic             fire, head;
  logic [CNT_W-1:0] remain;

  inv_tx_loader #(
    .DATA_W(DATA_W), .BUF_W(BUF_W), .SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)
  ) loader_i (
    .busy(busy), .load_valid(load_valid), .load_data(load_data),
    .sync_req(sync_req), .kind(kind), .img(img), .cnt(cnt_ld)
  );

  inv_tx_shifter #(.BUF_W(BUF_W), .CNT_W(CNT_W)) shifter_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .kind(kind), .img(img),
    .cnt_in(cnt_ld), .fire(fire), .head(head), .remain(remain)
  );

  inv_tx_line #(.CNT_W(CNT_W)) line_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .kind(kind), .fire(fire),
    .head(head), .remain(remain), .busy(busy), .pin(tx_pin)
  );
endmodule

// File: rtl/inv_uart_tx_chk.sv
module inv_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic load_valid,
  input logic sync_req,
  input logic busy,
  input logic tx_pin
);
  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(tx_pin));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tx_pin == 1'b0));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (load_valid || sync_req)) |=> busy);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> busy);
endmodule

bind inv_uart_tx inv_uart_tx_chk chk_i (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .load_valid(load_valid),
  .sync_req(sync_req), .busy(busy), .tx_pin(tx_pin)
);

// File: tb/inv_uart_tx_tb.sv
module inv_uart_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = '0;
  logic       sync_req = 1'b0;
  logic       busy, tx_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  inv_uart_tx dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .load_valid(load_valid),
    .load_data(load_data), .sync_req(sync_req), .busy(busy), .tx_pin(tx_pin)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_pin == 1'b0, "R1", "pin in reset", tx_pin, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_pin == 1'b0 && busy == 1'b0, "R1", "after reset", {busy, tx_pin}, 0);
  endtask

  // Sends one character; optionally raises sync_req alongside the load (R7)
  // and optionally pokes both requests mid-frame (R8).
  task automatic t_frame(input logic [7:0] d, input bit with_sync,
                         input bit disturb, input string req);
    logic exp_bit;
    @(negedge clk);
    load_data  = d;
    load_valid = 1'b1;
    sync_req   = with_sync;
    @(negedge clk);
    load_valid = 1'b0;
    sync_req   = 1'b0;
    check(busy == 1'b1, "R2", "busy after load", busy, 1);
    check(tx_pin == 1'b0, "R2", "pin before first tick", tx_pin, 0);
    for (int i = 0; i < 10; i++) begin
      do_tick();
      exp_bit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
      check(tx_pin == ~exp_bit, req, $sformatf("bit %0d of 0x%0h", i, d),
            tx_pin, int'(~exp_bit));
      check(busy == 1'b1, "R5", $sformatf("busy in bit %0d", i), busy, 1);
      if (disturb && i == 3) begin
        load_data  = 8'h0F;
        load_valid = 1'b1;
        sync_req   = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        sync_req   = 1'b0;
      end
      repeat (2) @(negedge clk);
      check(tx_pin == ~exp_bit, "R9", "pin held between ticks", tx_pin, int'(~exp_bit));
    end
    do_tick();
    check(busy == 1'b0, "R5", "busy after last period", busy, 0);
    check(tx_pin == 1'b0, "R4", "pin idle after frame", tx_pin, 0);
    if (disturb) begin
      for (int k = 0; k < 3; k++) begin
        do_tick();
        check(tx_pin == 1'b0 && busy == 1'b0, "R8", "no follow-on after ignored request",
              {busy, tx_pin}, 0);
      end
    end
  endtask

  task automatic t_sync();
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
    check(busy == 1'b1, "R6", "busy after burst request", busy, 1);
    for (int i = 0; i < 8; i++) begin
      do_tick();
      check(tx_pin == 1'b0, "R6", $sformatf("burst bit %0d", i), tx_pin, 0);
      check(busy == 1'b1, "R6", $sformatf("busy in burst bit %0d", i), busy, 1);
    end
    do_tick();
    check(busy == 1'b0, "R6", "busy after burst", busy, 0);
    check(tx_pin == 1'b0, "R6", "pin after burst", tx_pin, 0);
  endtask

  task automatic t_idle_ticks();
    for (int i = 0; i < 3; i++) begin
      do_tick();
      check(tx_pin == 1'b0 && busy == 1'b0, "R9", "idle tick", {busy, tx_pin}, 0);
    end
  endtask

  initial begin
    t_reset();
    t_idle_ticks();
    t_frame(8'hA5, 1'b0, 1'b0, "R3");
    t_frame(8'h00, 1'b0, 1'b0, "R4");
    t_frame(8'hFF, 1'b0, 1'b0, "R4");
    t_frame(8'h01, 1'b0, 1'b0, "R3");
    t_sync();
    t_frame(8'h00, 1'b1, 1'b0, "R7");
    t_frame(8'h3C, 1'b0, 1'b1, "R8");
    t_sync();
    t_frame(8'h80, 1'b0, 1'b0, "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule